// File: doc/BRIEF.md
# Byte-Lane Load/Store Memory Port

This block connects a processor's load/store path to a RAM that is 32 bits wide and can be written one byte lane at a time. The processor presents a byte address, an access size, a direction, a signedness flag and store data. The block sends the word address (byte address bits 31..2) to the RAM and drives four byte-lane write strobes. It also places the store data on every lane, so whichever lanes are enabled hold the right bytes.

The two lowest address bits stay inside the block. On a store they pick the strobe pattern. On a load they pick which byte or half-word of the returned 32-bit word is extracted. The extracted value is then sign- or zero-extended. A request that is not aligned to its own size is refused: the block pulses a fault output and sends nothing to the RAM.

Top module: `byte_lane_mem_port`

## Requirements
- R1: For every accepted request, `mem_addr` equals `req_addr[31:2]` and `mem_req` is high in the same cycle as `req_valid`. With `req_valid` low, `mem_req` and `mem_we` are zero.
- R2: Size encoding: 00 is byte, 01 is half-word, 10 is word, and 11 is handled exactly like word. An aligned word store drives `mem_we` = 4'b1111.
- R3: A half-word store at offset 0 drives `mem_we` = 4'b0011. At offset 2 it drives 4'b1100.
- R4: A byte store at offset n (0..3) drives `mem_we` = 1 << n. Byte n of the data word is bits 8n+7..8n.
- R5: A half-word request with `req_addr[0]` set, or a word request with either low bit set, raises `align_fault` in that same cycle. It keeps `mem_req` low and `mem_we` zero, and produces no read result. Byte requests never fault.
- R6: A load drives `mem_req` high with `mem_we` = 4'b0000.
- R7: Store data is replicated across lanes. A byte store puts `{4{wdata[7:0]}}` on `mem_wdata`. A half-word store puts `{2{wdata[15:0]}}`. A word store passes `wdata` through unchanged.
- R8: `rd_valid` is high exactly one cycle after each cycle in which `mem_rvalid` is high. `rd_data` then holds the lane or lanes selected by the address offset of the load that was issued.
- R9: With `req_signed` high, byte and half-word loads are sign-extended to 32 bits. With it low, they are zero-extended. Word loads return all 32 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size (00 byte, 01 half, 10/11 word) |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Full word returned by RAM |
| mem_rvalid | input | 1 | `mem_rdata` valid this cycle |
| mem_req | output | 1 | Memory access issued |
| mem_addr | output | 30 | Word address |
| mem_we | output | 4 | Per-lane write enables, active high |
| mem_wdata | output | 32 | Lane-replicated store data |
| align_fault | output | 1 | Misaligned request refused |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 32 | Extended load result |

## Verification
The assertions assume that the RAM raises `mem_rvalid` only in answer to a load the block issued, and that no second load is issued before the data for the previous one has been returned. The bench's RAM model always answers exactly one cycle after the load request, so back-to-back loads meet this assumption. Each request is held for a single cycle. With the request pulse that short, the fault output is a one-cycle pulse.

// File: rtl/lane_bus_pkg.sv
package lane_bus_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int ADDR_W  = 32;
    localparam int WADDR_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e        size;
        logic             sext;
        logic [OFF_W-1:0] offset;
    } load_ctx_t;

    function automatic logic is_misaligned(acc_size_e s, logic [OFF_W-1:0] off);
        case (s)
            ACC_BYTE: return 1'b0;
            ACC_HALF: return off[0];
            default:  return |off;
        endcase
    endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_bus_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] offset,
    output logic [LANES-1:0] lane_hit,
    output logic             misaligned
);
    assign misaligned = is_misaligned(size, offset);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        always_comb begin
            case (size)
                ACC_BYTE: lane_hit[n] = (OFF_W'(n) == offset);
                ACC_HALF: lane_hit[n] = (OFF_W'(n) >> 1) == (offset >> 1);
                default:  lane_hit[n] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/store_steer.sv
module store_steer
    import lane_bus_pkg::*;
(
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        always_comb begin
            case (size)
                ACC_BYTE: lane_data[8*n +: 8] = wdata[7:0];
                ACC_HALF: lane_data[8*n +: 8] = wdata[8*(n % 2) +: 8];
                default:  lane_data[8*n +: 8] = wdata[8*n +: 8];
            endcase
        end
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import lane_bus_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  load_ctx_t         ctx,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    assign byte_sel = word[8*ctx.offset +: 8];
    assign half_sel = word[16*ctx.offset[OFF_W-1] +: 16];

    always_comb begin
        case (ctx.size)
            ACC_BYTE: result = {{(DATA_W-8){ctx.sext & byte_sel[7]}}, byte_sel};
            ACC_HALF: result = {{(DATA_W-16){ctx.sext & half_sel[15]}}, half_sel};
            default:  result = word;
        endcase
    end
endmodule

// File: rtl/byte_lane_mem_port.sv
module byte_lane_mem_port
    import lane_bus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        req_signed,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_rvalid,
    output logic        mem_req,
    output logic [29:0] mem_addr,
    output logic [3:0]  mem_we,
    output logic [31:0] mem_wdata,
    output logic        align_fault,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    acc_size_e        size;
    logic [OFF_W-1:0] offset;
    logic [LANES-1:0] lane_hit;
    logic             misaligned;
    logic             issue;
    load_ctx_t        ctx_q;
    logic [DATA_W-1:0] extracted;

    assign size   = acc_size_e'(req_size);
    assign offset = req_addr[OFF_W-1:0];

    lane_decode u_decode (
        .size       (size),
        .offset     (offset),
        .lane_hit   (lane_hit),
        .misaligned (misaligned)
    );

    store_steer u_steer (
        .size      (size),
        .wdata     (req_wdata),
        .lane_data (mem_wdata)
    );

    load_extract u_extract (
        .word   (mem_rdata),
        .ctx    (ctx_q),
        .result (extracted)
    );

    assign issue       = req_valid & ~misaligned;
    assign mem_req     = issue;
    assign mem_addr    = req_addr[ADDR_W-1:OFF_W];
    assign mem_we      = (issue & req_write) ? lane_hit : '0;
    assign align_fault = req_valid & misaligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (issue && !req_write)
                ctx_q <= '{size: size, sext: req_signed, offset: offset};
            rd_valid <= mem_rvalid;
            if (mem_rvalid)
                rd_data <= extracted;
        end
    end

    a_r5_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> (!mem_req && mem_we == 4'b0000));

    a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_req && req_write && req_size[1]) |-> (mem_we == 4'b1111));

    a_r3_half_two_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_req && req_write && req_size == 2'b01) |->
            ($countones(mem_we) == 2 && (mem_we == 4'b0011 || mem_we == 4'b1100)));

    a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_req && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

    a_r6_load_no_we: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !req_write) |-> (mem_we == 4'b0000));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!mem_req && mem_we == 4'b0000 && !align_fault));

    a_r8_result_follows: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |=> rd_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !mem_rvalid |=> !rd_valid);

endmodule

// File: tb/byte_lane_mem_port_bench.sv
module byte_lane_mem_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [31:0] mem_rdata;
    logic        mem_rvalid;
    logic        mem_req, align_fault, rd_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata, rd_data;

    int tests = 0, fails = 0;
    bit done = 0;

    // model pipeline for load results
    logic        s1_v = 0, s2_v = 0;
    logic [31:0] s1_d = '0, s2_d = '0;
    logic        exp_load_v = 0;
    logic [31:0] exp_load_d = '0;

    always #2 clk = ~clk;

    byte_lane_mem_port u_byte_lane_mem_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .align_fault(align_fault),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] ram_word(input logic [29:0] wa);
        return 32'hF1807F02 ^ {wa[7:0], wa[7:0] + 8'd3, wa[7:0] + 8'd5, wa[7:0] + 8'd7};
    endfunction

    // RAM model: answers one cycle after a load request
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && (mem_we == 4'b0000);
            mem_rdata  <= ram_word(mem_addr);
        end
    end

    always @(posedge clk) begin
        s1_v <= !rst && exp_load_v;
        s1_d <= exp_load_d;
        s2_v <= !rst && s1_v;
        s2_d <= s1_d;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // R8/R9: compare registered result against the model every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 rd_valid", {31'd0, rd_valid}, {31'd0, s2_v});
            if (s2_v) check("R9 rd_data", rd_data, s2_d);
        end
    end

    task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                          input logic [31:0] a, input logic [31:0] wd);
        int off = int'(a[1:0]);
        int bytes = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        bit bad = (a % bytes) != 0;
        logic [3:0]  ewe;
        logic [31:0] ewd, word, v;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_signed = sg;
        req_addr = a; req_wdata = wd;
        ewe = 4'((1 << bytes) - 1) << off;
        if (bytes == 1)      ewd = {4{wd[7:0]}};
        else if (bytes == 2) ewd = {2{wd[15:0]}};
        else                 ewd = wd;
        word = ram_word(a[31:2]);
        v = word >> (8 * off);
        if (bytes == 1)      v = sg ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
        else if (bytes == 2) v = sg ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
        exp_load_v = !wr && !bad;
        exp_load_d = v;
        #1;
        check("R5 align_fault", {31'd0, align_fault}, {31'd0, bad});
        check("R1 mem_req", {31'd0, mem_req}, {31'd0, !bad});
        if (!bad) check("R1 mem_addr", {2'd0, mem_addr}, {2'd0, a[31:2]});
        if (bad)        check("R5 mem_we", {28'd0, mem_we}, 32'd0);
        else if (!wr)   check("R6 mem_we", {28'd0, mem_we}, 32'd0);
        else if (bytes == 4) check("R2 mem_we", {28'd0, mem_we}, {28'd0, ewe});
        else if (bytes == 2) check("R3 mem_we", {28'd0, mem_we}, {28'd0, ewe});
        else            check("R4 mem_we", {28'd0, mem_we}, {28'd0, ewe});
        if (wr && !bad) check("R7 mem_wdata", mem_wdata, ewd);
        @(posedge clk);
        #0.5;
        req_valid = 0; exp_load_v = 0;
    endtask

    initial begin
        #(4 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 idle mem_req", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        rst = 0;
        // stores: every byte offset, both half offsets, word and size 11
        for (int o = 0; o < 4; o++) access(1, 2'b00, 0, 32'h0000_1230 + o, 32'hC3A5_5A3C);
        access(1, 2'b01, 0, 32'h0000_2000, 32'hDEAD_BEEF);
        access(1, 2'b01, 0, 32'h0000_2002, 32'h1234_8001);
        access(1, 2'b10, 0, 32'h8000_0004, 32'h0BAD_F00D);
        access(1, 2'b11, 0, 32'h8000_0008, 32'h7654_3210);
        // loads: all widths and offsets, signed and unsigned, back to back
        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 4; o++) access(0, 2'b00, s[0], 32'h0000_0100 + 4*o + o, '0);
            access(0, 2'b01, s[0], 32'h0000_0380, '0);
            access(0, 2'b01, s[0], 32'h0000_0382, '0);
            access(0, 2'b10, s[0], 32'h0000_0FF0, '0);
            access(0, 2'b11, s[0], 32'hFFFF_FFFC, '0);
        end
        // misaligned requests
        access(1, 2'b01, 0, 32'h0000_0041, 32'hFFFF_FFFF);
        access(1, 2'b01, 0, 32'h0000_0043, 32'hFFFF_FFFF);
        for (int o = 1; o < 4; o++) access(1, 2'b10, 0, 32'h0000_0050 + o, 32'hFFFF_FFFF);
        access(0, 2'b01, 1, 32'h0000_0061, '0);
        access(0, 2'b10, 1, 32'h0000_0062, '0);
        access(0, 2'b11, 1, 32'h0000_0063, '0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule